// File: doc/BRIEF.md
# Fractional microsecond tick generator

This block turns a reference clock of arbitrary frequency into a steady one-microsecond time base. A small rational divider, set by a 16-bit configuration word, adds a numerator to an accumulator on every reference cycle. Each time the sum reaches the denominator, the divider subtracts the denominator and emits a one-cycle tick. This lets a reference such as 19.2 MHz give exactly five ticks every 96 cycles, so the average period is exactly 1 µs.

Every tick advances a free-running microsecond counter. A simple register port reads and writes the configuration word and reads the counter. The tick pulse also leaves the block on its own pin so that neighbouring timers can share the same time base. A freeze input stops the time base for as long as it is held high.

Top module: `ufrac_us_timer`

## Requirements
- R1: While reset is low and just after it is released, the counter reads 0, the configuration reads 0x0000000B, `tick_o` is low and the accumulator is empty.
- R2: Register address 0 is the configuration word. A write stores `reg_wdata[15:0]`, and reads return exactly that value zero-extended to 32 bits. Bits [15:8] hold the numerator minus one, and bits [7:0] hold the denominator minus one.
- R3: `tick_o` is a pulse one cycle wide. The counter at register address 1 grows by one in exactly the cycle in which `tick_o` is high, and at no other time.
- R4: When the numerator is less than the denominator, N active cycles after the accumulator is cleared give floor(N·numerator/denominator) ticks. Examples: 0x000B gives one tick every 12 cycles, 0x000C gives one every 13, 0x0019 gives one every 26, and 0x045F gives 5 ticks per 96 cycles.
- R5: The counter is 32 bits wide by default and wraps modulo 2^COUNT_W.
- R6: A write to address 1, 2 or 3 changes neither the counter nor the configuration. Reads of addresses 2 and 3 return 0.
- R7: While `freeze` is high and no configuration write occurs, the accumulator and the counter hold their values and `tick_o` stays low. Counting resumes from the held accumulator once `freeze` falls.
- R8: A configuration write empties the accumulator and suppresses any tick on that edge, and it leaves the counter unchanged. It takes effect even while `freeze` is high.
- R9: When the numerator is greater than or equal to the denominator, a tick is produced on every active cycle and the accumulator stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freeze | input | 1 | Halts the accumulator and the counter while high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (2) | Register address: 0 configuration, 1 counter |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| tick_o | output | 1 | One-cycle microsecond tick |

## Verification
Two events can land on the same clock edge: a configuration write and the accumulator overflow that would otherwise produce a tick. The bench lets the accumulator count up to one cycle before an overflow and then issues the write on the overflow edge. The write must win: no tick appears, the counter holds its value, and the next tick comes a full period later. A second overlap, a configuration write while frozen, is judged by reading back the new word and watching the restarted period after the freeze is released. A behavioural model is also compared with `tick_o` and the read port on every cycle.

// File: rtl/ufrac_pkg.sv
package ufrac_pkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 2 * FIELD_W;
  localparam int ACC_W   = FIELD_W + 2;

  typedef struct packed {
    logic             tick;
    logic [ACC_W-1:0] acc;
  } step_t;

  function automatic logic [ACC_W-1:0] numer_of(input logic [CFG_W-1:0] cfg);
    return {{(ACC_W-FIELD_W){1'b0}}, cfg[CFG_W-1:FIELD_W]} + ACC_W'(1);
  endfunction

  function automatic logic [ACC_W-1:0] denom_of(input logic [CFG_W-1:0] cfg);
    return {{(ACC_W-FIELD_W){1'b0}}, cfg[FIELD_W-1:0]} + ACC_W'(1);
  endfunction

  function automatic step_t accum_step(input logic [ACC_W-1:0] acc,
                                       input logic [ACC_W-1:0] numer,
                                       input logic [ACC_W-1:0] denom);
    step_t            r;
    logic [ACC_W-1:0] sum;
    sum = acc + numer;
    if (numer >= denom) begin
      r.tick = 1'b1;
      r.acc  = '0;
    end else if (sum >= denom) begin
      r.tick = 1'b1;
      r.acc  = sum - denom;
    end else begin
      r.tick = 1'b0;
      r.acc  = sum;
    end
    return r;
  endfunction
endpackage

// File: rtl/ufrac_cfg_reg.sv
module ufrac_cfg_reg
  import ufrac_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = 16'h000B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic [ACC_W-1:0] numer,
  output logic [ACC_W-1:0] denom
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= RESET_CFG;
    else if (wr_en) cfg_q <= wdata;
  end

  assign numer = numer_of(cfg_q);
  assign denom = denom_of(cfg_q);
endmodule

// File: rtl/ufrac_accum.sv
module ufrac_accum
  import ufrac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hold,
  input  logic [ACC_W-1:0] numer,
  input  logic [ACC_W-1:0] denom,
  output logic [ACC_W-1:0] acc_q,
  output logic             tick_q,
  output logic             wrap_evt
);
  step_t nxt;

  always_comb nxt = accum_step(acc_q, numer, denom);

  assign wrap_evt = nxt.tick && !clear && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (clear) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (hold) begin
      tick_q <= 1'b0;
    end else begin
      acc_q  <= nxt.acc;
      tick_q <= nxt.tick;
    end
  end
endmodule

// File: rtl/ufrac_counter.sv
module ufrac_counter #(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  output logic [COUNT_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count_q <= '0;
    else if (inc) count_q <= count_q + COUNT_W'(1);
  end
endmodule

// File: rtl/ufrac_us_timer.sv
module ufrac_us_timer
  import ufrac_pkg::*;
#(
  parameter int               COUNT_W   = 32,
  parameter int               DATA_W    = 32,
  parameter int               ADDR_W    = 2,
  parameter logic [CFG_W-1:0] RESET_CFG = 16'h000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tick_o
);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(1);

  logic               cfg_wr;
  logic [CFG_W-1:0]   cfg_q;
  logic [ACC_W-1:0]   numer;
  logic [ACC_W-1:0]   denom;
  logic [ACC_W-1:0]   acc_q;
  logic               wrap_evt;
  logic [COUNT_W-1:0] count_q;

  assign cfg_wr = reg_wr && (reg_addr == CFG_ADDR);

  ufrac_cfg_reg #(.RESET_CFG(RESET_CFG)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(reg_wdata[CFG_W-1:0]),
    .cfg_q(cfg_q), .numer(numer), .denom(denom)
  );

  ufrac_accum acc_i (
    .clk(clk), .rst_n(rst_n), .clear(cfg_wr), .hold(freeze),
    .numer(numer), .denom(denom), .acc_q(acc_q), .tick_q(tick_o),
    .wrap_evt(wrap_evt)
  );

  ufrac_counter #(.COUNT_W(COUNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(wrap_evt), .count_q(count_q)
  );

  always_comb begin
    case (reg_addr)
      CFG_ADDR: reg_rdata = DATA_W'(cfg_q);
      CNT_ADDR: reg_rdata = DATA_W'(count_q);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

module ufrac_us_timer_chk
  import ufrac_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               freeze,
  input logic               cfg_wr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [CFG_W-1:0]   cfg_q,
  input logic [ACC_W-1:0]   acc_q,
  input logic [ACC_W-1:0]   denom,
  input logic               tick_o,
  input logic [COUNT_W-1:0] count_q
);
  // R2
  cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_q == $past(reg_wdata[CFG_W-1:0]));
  // R8
  write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (acc_q == '0) && !tick_o && $stable(count_q));
  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cfg_wr) |=> $stable(acc_q) && $stable(count_q) && !tick_o);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> count_q == COUNT_W'($past(count_q) + COUNT_W'(1)));
  // R3
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |-> $stable(count_q));
  // R4
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == '0) || (acc_q < denom));
endmodule

bind ufrac_us_timer ufrac_us_timer_chk #(.COUNT_W(COUNT_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .freeze(freeze), .cfg_wr(cfg_wr),
  .reg_wdata(reg_wdata), .cfg_q(cfg_q), .acc_q(acc_q), .denom(denom),
  .tick_o(tick_o), .count_q(count_q)
);

// File: tb/ufrac_us_timer_test.sv
`timescale 1ns/100ps
module ufrac_us_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_o;
  logic [31:0] n_rdata;
  logic        n_tick;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ufrac_us_timer uut (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_o(tick_o)
  );

  ufrac_us_timer #(.COUNT_W(8), .RESET_CFG(16'h0000)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .freeze(1'b0), .reg_wr(1'b0),
    .reg_addr(2'd1), .reg_wdata(32'd0), .reg_rdata(n_rdata),
    .tick_o(n_tick)
  );

  // behavioural reference model
  longint m_cfg, m_acc, m_cnt;
  bit     m_tick;

  always @(posedge clk) begin
    longint num, den;
    if (!rst_n) begin
      m_cfg = 11; m_acc = 0; m_cnt = 0; m_tick = 0;
    end else if (reg_wr && reg_addr == 2'd0) begin
      m_cfg = reg_wdata & 32'hFFFF; m_acc = 0; m_tick = 0;
    end else if (freeze) begin
      m_tick = 0;
    end else begin
      num = (m_cfg / 256) + 1;
      den = (m_cfg % 256) + 1;
      m_tick = 0;
      if (num >= den) begin
        m_tick = 1; m_acc = 0;
      end else begin
        m_acc = m_acc + num;
        if (m_acc >= den) begin
          m_acc = m_acc - den; m_tick = 1;
        end
      end
      if (m_tick) m_cnt = (m_cnt + 1) % 64'h1_0000_0000;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] e;
      string t;
      check("R3 tick vs model", {31'd0, tick_o}, {31'd0, m_tick});
      case (reg_addr)
        2'd0: begin e = 32'(m_cfg); t = "R2 rdata vs model"; end
        2'd1: begin e = 32'(m_cnt); t = "R5 rdata vs model"; end
        default: begin e = 0; t = "R6 rdata vs model"; end
      endcase
      check(t, reg_rdata, e);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic samp(output logic [31:0] d);
    #0.5;
    d = reg_rdata;
  endtask

  task automatic write_cfg(logic [31:0] v);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = v;
    step(1);
    reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] c0, c1, d;
    int first, last, nt;
    // R1 reset state
    repeat (3) @(negedge clk);
    #0.5;
    samp(d); check("R1 counter in reset", d, 0);
    check("R1 tick in reset", {31'd0, tick_o}, 0);
    reg_addr = 2'd0; samp(d); check("R1 config in reset", d, 32'h0000000B);
    reg_addr = 2'd1;
    step(1);
    rst_n = 1'b1;

    // R5 wrap on narrow instance, R9 tick every cycle, R4 default rate
    step(300);
    #0.5;
    check("R5 narrow counter wrap", n_rdata, 32'd44);
    check("R9 narrow tick each cycle", {31'd0, n_tick}, 1);
    check("R4 default rate 300 cycles", reg_rdata, 32'd25);

    // R4 tick spacing at 0x000B
    step(1);
    write_cfg(32'h000B);
    first = -1; last = -1; nt = 0;
    for (int i = 1; i <= 36; i++) begin
      step(1); #0.5;
      if (tick_o) begin
        nt++;
        if (first < 0) first = i;
        else check("R4 spacing 12", i - last, 12);
        last = i;
      end
    end
    check("R4 first tick at 12", first, 12);
    check("R3 tick count 36 cycles", nt, 3);

    // R4 0x045F: 4 ticks in 95 cycles, 5 in 96
    step(1);
    write_cfg(32'h045F);
    samp(c0);
    step(95); samp(c1); check("R4 19.2 ratio 95 cycles", c1 - c0, 4);
    step(1);  samp(c1); check("R4 19.2 ratio 96 cycles", c1 - c0, 5);

    // R4 0x000C and 0x0019
    step(1);
    write_cfg(32'h000C); samp(c0);
    step(39); samp(c1); check("R4 13 ratio", c1 - c0, 3);
    step(1);
    write_cfg(32'h0019); samp(c0);
    step(52); samp(c1); check("R4 26 ratio", c1 - c0, 2);

    // R9 numerator above denominator
    step(1);
    write_cfg(32'h0300); samp(c0);
    step(10); samp(c1); check("R9 saturated rate", c1 - c0, 10);

    // R8 write on the overflow edge
    step(1);
    write_cfg(32'h000B);
    step(11); samp(c0);
    write_cfg(32'h000B);
    #0.5;
    check("R8 tick suppressed", {31'd0, tick_o}, 0);
    check("R8 counter unchanged", reg_rdata, c0);
    step(11); #0.5; check("R8 no early tick", {31'd0, tick_o}, 0);
    step(1); #0.5;
    check("R8 tick one period later", {31'd0, tick_o}, 1);
    check("R8 counter after period", reg_rdata, c0 + 1);

    // R7 freeze holds state
    step(1);
    write_cfg(32'h000B);
    step(5); samp(c0);
    freeze = 1'b1;
    nt = 0;
    for (int i = 0; i < 40; i++) begin
      step(1); #0.5;
      if (tick_o) nt++;
    end
    check("R7 no tick while frozen", nt, 0);
    check("R7 counter held", reg_rdata, c0);
    step(0);
    freeze = 1'b0;
    step(6); #0.5; check("R7 accumulator held", {31'd0, tick_o}, 0);
    step(1); #0.5; check("R7 resume tick", {31'd0, tick_o}, 1);

    // R8 write while frozen
    step(1);
    freeze = 1'b1;
    write_cfg(32'h0019);
    reg_addr = 2'd0; samp(d); check("R8 write while frozen", d, 32'h0019);
    reg_addr = 2'd1;

    // R6 writes to counter and spare addresses ignored
    step(1);
    samp(c0);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'hDEADBEEF;
    step(1);
    reg_addr = 2'd3;
    step(1);
    reg_wr = 1'b0; reg_addr = 2'd1;
    samp(d); check("R6 counter write ignored", d, c0);
    reg_addr = 2'd0; samp(d); check("R6 config untouched", d, 32'h0019);
    reg_addr = 2'd2; samp(d); check("R6 spare address reads 0", d, 0);
    freeze = 1'b0;

    // R2 readback keeps low half only
    step(1);
    write_cfg(32'hFFFF1234);
    reg_addr = 2'd0; samp(d); check("R2 readback low half", d, 32'h00001234);
    reg_addr = 2'd1;
    step(20);

    done = 1;
    summary();
    $finish;
  end
endmodule